// File: doc/BRIEF.md
# Change-Triggered Mute and Flush Controller

This block sits beside an audio sample path. It turns any disturbance on the input side into a single "need to mute" condition. There are four kinds of disturbance: a format or rate change, a change of the selected input, a loss of lock, and a stream error. While that condition holds, downstream stages are told to empty their sample buffers and drop partly accumulated filter results, and the noise-shaping modulator is told to stay silent. Left and right samples travel as one unit, so one flush request, one mute flag and one gain value serve both channels.

The mute condition can be retriggered. It holds for a fixed number of clock cycles counted from the latest event, and every new event restarts that count. When the hold ends, the block does not unmute at once. It produces a gain word that climbs linearly from zero to full scale over a set ramp time. A new event during the climb pulls the gain straight back to zero. At the intended system clock the defaults give a hold of about 4 ms and a ramp of about 10 ms. Reset behaves exactly like an event, so the path starts up muted and then fades in.

Top module: `mute_flush_ctrl`

## Requirements
- R1: When any of the four event inputs is high, `mute_o` and `flush_o` are high in that same cycle, with no register in the path.
- R2: After the last clock edge that samples an event, `mute_o` stays high for exactly HOLD_CYCLES further cycles and then goes low. An event inside that window restarts the count from the new event.
- R3: `flush_o` is high in exactly the cycles in which `mute_o` is high.
- R4: `gain_o` is zero in every cycle in which `mute_o` is high.
- R5: Once `mute_o` has gone low, `gain_o` rises by exactly one LSB every RAMP_DIV cycles. RAMP_DIV is ceil(RAMP_CYCLES / (2^GAIN_W - 1)), with a minimum of 1. So the gain reads floor(m / RAMP_DIV) m cycles after the release.
- R6: `gain_o` never falls while unmuted and never rises by more than one LSB per cycle. Once it reaches full scale (all ones), it stays there until the next event.
- R7: An event that arrives while the gain is ramping forces `gain_o` to zero in that same cycle and starts a new hold interval. After that hold ends, the ramp starts again from zero.
- R8: While `rst_n` is low, the outputs read muted, flushing and zero gain. After release, the block holds for HOLD_CYCLES cycles and then ramps, just as after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_chg_i | input | 1 | Strobe: sample format or rate changed |
| sel_chg_i | input | 1 | Strobe: selected input changed |
| lock_lost_i | input | 1 | Strobe: receiver lost lock |
| stream_err_i | input | 1 | Strobe: error seen in the stream |
| flush_o | output | 1 | Request to clear buffers and drop partial filter results |
| mute_o | output | 1 | Modulator mute flag |
| gain_o | output | GAIN_W | Unsigned gain for both channels, all ones is full scale |

## Verification
The assertions assume that the event inputs are clean synchronous levels sampled on `clk`, and that reset is asserted from time zero, so that the history used by the past-value checks always starts in the muted state. The hold-length check counts quiet cycles in a counter of its own, because HOLD_CYCLES may be far too large to unroll. The bench drives every event and reset change just after a falling edge, so the inputs are stable at each rising edge. It runs the design with a short hold and ramp, so every exact cycle count can be checked in full.

// File: rtl/mfc_pkg.sv
// Package mfc_pkg
// Shared constants and types for the mute and flush controller.
// Assumes nothing beyond the parameters chosen at the top level.
package mfc_pkg;

    // Number of disturbance sources merged into the mute request
    localparam int NUM_EVENTS = 4;

    // Phase of the output gain
    typedef enum logic [1:0] {
        RAMP_MUTED  = 2'd0,
        RAMP_RISING = 2'd1,
        RAMP_FULL   = 2'd2
    } ramp_state_t;

    // Divider between gain steps for a ramp of ramp_cycles to full scale
    function automatic int ramp_divider(input int ramp_cycles, input int gain_max);
        int d;
        d = (ramp_cycles + gain_max - 1) / gain_max;
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/mfc_event_merge.sv
// Module mfc_event_merge
// Merges the disturbance strobes into one combinational event flag.
// Assumes the strobes are already synchronous to clk.
module mfc_event_merge #(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               any_o
);

    logic [NUM_SRC:0] chain;

    // Seed of the OR chain
    assign chain[0] = 1'b0;

    // One OR stage per source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | evt_i[g];
    end

    assign any_o = chain[NUM_SRC];

endmodule

// File: rtl/mfc_hold_timer.sv
// Module mfc_hold_timer
// Retriggerable hold: active at once on an event, then for HOLD_CYCLES
// cycles after the last edge that sampled an event. Reset loads the hold
// exactly as an event does.
// Assumes HOLD_CYCLES >= 1.
module mfc_hold_timer #(
    parameter int HOLD_CYCLES = 903168
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic hold_o
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          held_q;

    // Load on reset or event, count down while held, release at zero
    always_ff @(posedge clk) begin
        if (!rst_n || evt_i) begin
            held_q <= 1'b1;
            cnt_q  <= RELOAD;
        end else if (held_q) begin
            if (cnt_q == '0) begin
                held_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Event bypasses the register so the request rises in the same cycle
    assign hold_o = held_q | evt_i;

endmodule

// File: rtl/mfc_gain_ramp.sv
// Module mfc_gain_ramp
// Linear fade-in: while muted the gain is zero; once unmuted it steps
// up one LSB every RAMP_DIV cycles and saturates at full scale.
// Assumes mute_i already holds the combinational event path.
module mfc_gain_ramp
    import mfc_pkg::*;
#(
    parameter int GAIN_W      = 16,
    parameter int RAMP_CYCLES = 2257920
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_i,
    output logic [GAIN_W-1:0] gain_o
);

    localparam int GAIN_MAX = (1 << GAIN_W) - 1;
    localparam int RAMP_DIV = ramp_divider(RAMP_CYCLES, GAIN_MAX);
    localparam int DW       = $clog2(RAMP_DIV + 1);
    localparam logic [DW-1:0]     DIV_LAST = DW'(RAMP_DIV - 1);
    localparam logic [GAIN_W-1:0] FULL     = GAIN_W'(GAIN_MAX);

    ramp_state_t       state_q;
    logic [GAIN_W-1:0] gain_q;
    logic [DW-1:0]     div_q;
    logic [GAIN_W-1:0] gain_next;

    // Candidate for the next gain step
    always_comb gain_next = gain_q + 1'b1;

    // Gain stepping and phase tracking
    always_ff @(posedge clk) begin
        if (!rst_n || mute_i) begin
            state_q <= RAMP_MUTED;
            gain_q  <= '0;
            div_q   <= '0;
        end else begin
            unique case (state_q)
                RAMP_MUTED, RAMP_RISING: begin
                    if (div_q == DIV_LAST) begin
                        div_q   <= '0;
                        gain_q  <= gain_next;
                        state_q <= (gain_next == FULL) ? RAMP_FULL : RAMP_RISING;
                    end else begin
                        div_q   <= div_q + 1'b1;
                        state_q <= RAMP_RISING;
                    end
                end
                RAMP_FULL: begin
                    gain_q <= FULL;
                end
                default: begin
                    state_q <= RAMP_MUTED;
                    gain_q  <= '0;
                end
            endcase
        end
    end

    // Muting wins at once, without waiting for the register
    assign gain_o = mute_i ? '0 : gain_q;

endmodule

// File: rtl/mute_flush_ctrl.sv
// Module mute_flush_ctrl
// Top level: merges disturbance strobes, holds the mute and flush request
// for a retriggerable interval, then fades the stereo gain back in.
// Assumes synchronous strobes and a synchronous active-low reset.
module mute_flush_ctrl
    import mfc_pkg::*;
#(
    parameter int HOLD_CYCLES = 903168,
    parameter int RAMP_CYCLES = 2257920,
    parameter int GAIN_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_chg_i,
    input  logic              sel_chg_i,
    input  logic              lock_lost_i,
    input  logic              stream_err_i,
    output logic              flush_o,
    output logic              mute_o,
    output logic [GAIN_W-1:0] gain_o
);

    logic [NUM_EVENTS-1:0] evt_vec;
    logic                  evt_any;
    logic                  hold;

    // Pack the strobes; the bit order carries no priority
    assign evt_vec = {stream_err_i, lock_lost_i, sel_chg_i, fmt_chg_i};

    mfc_event_merge #(
        .NUM_SRC (NUM_EVENTS)
    ) u_merge (
        .evt_i (evt_vec),
        .any_o (evt_any)
    );

    mfc_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_any),
        .hold_o (hold)
    );

    mfc_gain_ramp #(
        .GAIN_W      (GAIN_W),
        .RAMP_CYCLES (RAMP_CYCLES)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .mute_i (hold),
        .gain_o (gain_o)
    );

    // One request serves both buffer clearing and modulator muting
    assign flush_o = hold;
    assign mute_o  = hold;

endmodule

// File: rtl/mfc_checker.sv
// Module mfc_checker
// Property checks for mute_flush_ctrl, attached by bind below.
// Assumes reset is asserted from time zero.
module mfc_checker #(
    parameter int HOLD_CYCLES = 903168,
    parameter int GAIN_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fmt_chg_i,
    input logic              sel_chg_i,
    input logic              lock_lost_i,
    input logic              stream_err_i,
    input logic              flush_o,
    input logic              mute_o,
    input logic [GAIN_W-1:0] gain_o
);

    localparam int QW = $clog2(HOLD_CYCLES + 2);
    localparam logic [QW-1:0]     HOLD = QW'(HOLD_CYCLES);
    localparam logic [GAIN_W-1:0] FULL = '1;

    logic          evt;
    logic [QW-1:0] quiet_q;

    assign evt = fmt_chg_i | sel_chg_i | lock_lost_i | stream_err_i;

    // Cycles since the last edge that sampled an event or reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || evt) quiet_q <= '0;
        else if (quiet_q != HOLD) quiet_q <= quiet_q + 1'b1;
    end

    AST_EVENT_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (mute_o && flush_o)); // R1

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q < HOLD) |-> mute_o); // R2

    AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q == HOLD && !evt) |-> !mute_o); // R2

    AST_FLUSH_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o == mute_o); // R3

    AST_SILENT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        mute_o |-> (gain_o == '0)); // R4

    AST_RAMP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute_o) |-> (gain_o == '0)); // R5

    AST_GAIN_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_o && $past(!mute_o)) |-> (gain_o >= $past(gain_o))); // R6

    AST_GAIN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_o && $past(!mute_o)) |->
        ({1'b0, gain_o} <= ({1'b0, $past(gain_o)} + {{GAIN_W{1'b0}}, 1'b1}))); // R6

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gain_o) == FULL && !mute_o) |-> (gain_o == FULL)); // R6

    AST_RAMP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && $past(!mute_o)) |-> (gain_o == '0)); // R7

endmodule

bind mute_flush_ctrl mfc_checker #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .GAIN_W      (GAIN_W)
) u_mfc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_chg_i    (fmt_chg_i),
    .sel_chg_i    (sel_chg_i),
    .lock_lost_i  (lock_lost_i),
    .stream_err_i (stream_err_i),
    .flush_o      (flush_o),
    .mute_o       (mute_o),
    .gain_o       (gain_o)
);

// File: tb/test_mute_flush_ctrl.sv
// Directed bench for mute_flush_ctrl with a short hold and ramp.
module test_mute_flush_ctrl;

    localparam int HOLD  = 20;
    localparam int RAMP  = 30;
    localparam int GW    = 4;
    localparam int GMAX  = 15;
    localparam int DIV   = 2;   // ceil(30 / 15)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    ev = '0;
    logic          flush, mute;
    logic [GW-1:0] gain;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    mute_flush_ctrl #(
        .HOLD_CYCLES (HOLD),
        .RAMP_CYCLES (RAMP),
        .GAIN_W      (GW)
    ) i_mute_flush_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fmt_chg_i    (ev[0]),
        .sel_chg_i    (ev[1]),
        .lock_lost_i  (ev[2]),
        .stream_err_i (ev[3]),
        .flush_o      (flush),
        .mute_o       (mute),
        .gain_o       (gain)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to just after the next falling edge
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Raise one strobe for one cycle; check the same-cycle response
    task automatic pulse(input int idx);
        ev[idx] = 1'b1;
        #1;
        check("R1 mute on event", int'(mute), 1);
        check("R1 flush on event", int'(flush), 1);
        check("R7 gain zero on event", int'(gain), 0);
        step();
        ev = '0;
        #1;
    endtask

    // Count muted cycles; flush and gain are checked along the way
    task automatic measure_hold(input string req);
        int n = 0;
        while (mute && n < 4 * HOLD) begin
            if (flush !== mute) check("R3 flush equals mute", int'(flush), int'(mute));
            if (gain != '0) check("R4 gain zero while muted", int'(gain), 0);
            n++;
            step();
        end
        check(req, n, HOLD);
        check("R3 flush low after hold", int'(flush), 0);
        check("R5 gain starts at zero", int'(gain), 0);
    endtask

    // Follow the ramp for cnt cycles after release
    task automatic ramp_check(input int cnt);
        for (int m = 1; m <= cnt; m++) begin
            int e;
            step();
            e = (m / DIV > GMAX) ? GMAX : m / DIV;
            if (int'(gain) != e) check("R5 R6 ramp value", int'(gain), e);
            else checks++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) step();
        check("R8 reset mute", int'(mute), 1);
        check("R8 reset flush", int'(flush), 1);
        check("R8 reset gain", int'(gain), 0);
        rst_n = 1'b1;
        #1;
        measure_hold("R8 hold after reset");
        ramp_check(RAMP + 4);
    endtask

    task automatic t_each_event();
        for (int k = 0; k < 4; k++) begin
            pulse(k);
            measure_hold("R2 hold after single event");
            ramp_check(6);
        end
    endtask

    task automatic t_retrigger();
        pulse(2);
        for (int i = 0; i < 7; i++) step();
        check("R2 still muted mid hold", int'(mute), 1);
        pulse(3);
        measure_hold("R2 hold restarted by new event");
        ramp_check(4);
    endtask

    task automatic t_full_scale();
        pulse(0);
        measure_hold("R2 hold before full ramp");
        ramp_check(RAMP);
        check("R6 full scale reached", int'(gain), GMAX);
        for (int i = 0; i < 12; i++) step();
        check("R6 full scale kept", int'(gain), GMAX);
        check("R6 still unmuted", int'(mute), 0);
    endtask

    task automatic t_ramp_interrupt();
        pulse(1);
        measure_hold("R2 hold before interrupt");
        ramp_check(10);
        check("R7 mid ramp gain", int'(gain), 5);
        pulse(2);
        measure_hold("R7 hold re-entered");
        ramp_check(6);
        check("R7 ramp restarted", int'(gain), 3);
    endtask

    initial begin
        step();
        t_reset();
        t_each_event();
        t_retrigger();
        t_full_scale();
        t_ramp_interrupt();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule